// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block takes accepted Ethernet frames from a byte stream and lays them into a circular receive area of local memory. The area is counted in 256-byte pages. Software sets the first page of the ring, the page just past its end, and a boundary page that marks where its own reading has reached. The block keeps a current page that points to where the next frame will land.

Each incoming frame is collected whole in an internal staging store. The space test is made when the first byte arrives. Once the last byte is in, the block writes a 4-byte descriptor at the current page, followed by the frame bytes. The descriptor holds a status byte, the page where the following frame will start, and the stored length. Writing wraps from the end of the ring back to its first page. When the last byte is written, the current page moves on and a sticky receive flag is raised.

The stream input uses valid/ready. A beat is taken on a rising clock edge when `s_valid` and `s_ready` are both high. `s_ready` is high while the block is idle or collecting a frame. It drops from the cycle after the end marker is taken until the final memory write of that frame. The sender must hold its data and markers steady while `s_ready` is low. A beat that arrives while idle without a start marker is consumed and thrown away.

Top module: `rx_page_ring_writer`

## Requirements
- R1: After reset `cur_pg` is 0x00, `rx_flag`, `busy`, `drop` and `mem_we` are 0, and `s_ready` is 1.
- R2: At the start beat, with C = `cur_pg`·256, B = `bound_pg`·256, S = `ring_start_pg`·256 and E = `ring_stop_pg`·256, the free space is B−C when C < B and (E−S)−(C−B) otherwise. The frame is refused when this free space is below 1518.
- R3: A frame whose start beat arrives while `halt` is 1 is refused.
- R4: A refused frame is consumed up to its end marker with no memory write. `drop` pulses high for exactly one cycle, in the cycle after the start beat.
- R5: The descriptor occupies bytes +0..+3 of the current page. Byte +0 is the status, +1 the next page, +2 the low byte and +3 the high byte of the total, where total = stored length + 4.
- R6: The status is 0x01, with 0x20 added when bit 0 of the first frame byte is 1.
- R7: A frame shorter than 60 bytes is stored as 60 bytes, with zero bytes after its own.
- R8: With C as in R2, the next page is (C + ((total + 4 + 255) with the low 8 bits cleared))/256. If that address is at or beyond E, then (E−S) is subtracted first.
- R9: Frame bytes follow the descriptor at consecutive addresses. An address that reaches E continues at S.
- R10: In the cycle after the last frame byte is written, `cur_pg` holds the next page and `rx_flag` is 1. `rx_flag` stays set until `rx_flag_clr` is pulsed.
- R11: `busy` is 1 from the first descriptor write to the last data write, and `s_ready` is 0 whenever `busy` is 1.
- R12: A pulse on `cur_load` copies `cur_load_pg` into `cur_pg` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Receiver stopped; new frames are refused |
| ring_start_pg | input | 8 | First page of the ring |
| ring_stop_pg | input | 8 | Page one past the end of the ring |
| bound_pg | input | 8 | Software read boundary page |
| cur_load | input | 1 | Load the current page from `cur_load_pg` |
| cur_load_pg | input | 8 | Value for the current page |
| cur_pg | output | 8 | Current write page |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with valid |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Marks the first byte of a frame |
| s_eof | input | 1 | Marks the last byte of a frame |
| mem_we | output | 1 | Local memory byte write enable |
| mem_addr | output | 16 | Local memory byte address |
| mem_wdata | output | 8 | Local memory write byte |
| busy | output | 1 | Descriptor or frame bytes being written |
| drop | output | 1 | One-cycle pulse for a refused frame |
| rx_flag | output | 1 | Sticky frame-stored flag |
| rx_flag_clr | input | 1 | Clears `rx_flag` |

## Verification
The hardest case to reach is a frame that begins near the top of the ring. Its descriptor sits in the last page, its bytes cross from the stop address back to the start page, and its next-page result must also wrap. Many frames would be needed to walk the current page there. The stimulus instead loads the current page directly through `cur_load` and sets the boundary equal to it, so the space test sees a whole empty ring. One vector is then sized so the bytes run past the stop page. A second is sized so the next page lands exactly on the stop address and must be folded back.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {
    IN_IDLE,
    IN_FILL,
    IN_SKIP,
    IN_LAUNCH
  } in_state_e;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_HDR,
    WR_DATA
  } wr_phase_e;

  localparam logic [7:0] STAT_GOOD  = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;
endpackage

// File: rtl/rxr_space_chk.sv
module rxr_space_chk #(
  parameter int PAGE_W  = 8,
  parameter int RESERVE = 1518
) (
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  output logic              roomy
);
  localparam int W = PAGE_W + 10;

  logic signed [W-1:0] cur_s, bnd_s, sta_s, stp_s, avail_s;

  always_comb begin
    cur_s = $signed({2'b00, cur_pg, 8'h00});
    bnd_s = $signed({2'b00, bnd_pg, 8'h00});
    sta_s = $signed({2'b00, start_pg, 8'h00});
    stp_s = $signed({2'b00, stop_pg, 8'h00});
    if (cur_s < bnd_s) avail_s = bnd_s - cur_s;
    else               avail_s = (stp_s - sta_s) - (cur_s - bnd_s);
    roomy = (avail_s >= $signed(W'(RESERVE)));
  end
endmodule

// File: rtl/rxr_stage_ram.sv
module rxr_stage_ram #(
  parameter int SAW = 11
) (
  input  logic           clk,
  input  logic           we,
  input  logic [SAW-1:0] waddr,
  input  logic [7:0]     wdata,
  input  logic [SAW-1:0] raddr,
  output logic [7:0]     rdata
);
  localparam int DEPTH = 1 << SAW;

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/rxr_next_calc.sv
module rxr_next_calc #(
  parameter int PAGE_W    = 8,
  parameter int LEN_W     = 11,
  parameter int CRC_BYTES = 4
) (
  input  logic [PAGE_W-1:0] base_pg,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [LEN_W-1:0]  tot_len,
  output logic [PAGE_W-1:0] next_pg
);
  localparam int RW    = LEN_W + 2;
  localparam int ROUND = CRC_BYTES + 255;

  logic [RW-1:0]     rounded;
  logic [PAGE_W:0]   adv, sum, span;

  always_comb begin
    rounded = RW'(tot_len) + RW'(ROUND);
    adv     = (PAGE_W+1)'(rounded >> 8);
    sum     = {1'b0, base_pg} + adv;
    span    = {1'b0, stop_pg} - {1'b0, start_pg};
    if (sum >= {1'b0, stop_pg}) sum = sum - span;
    next_pg = sum[PAGE_W-1:0];
  end
endmodule

// File: rtl/rxr_wr_seq.sv
module rxr_wr_seq
  import rxr_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int LEN_W     = 11,
  parameter int SAW       = 11,
  parameter int MIN_FRAME = 60,
  parameter int HDR_BYTES = 4,
  parameter int CRC_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PAGE_W-1:0] base_pg,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [7:0]        status,
  output logic [SAW-1:0]    stg_raddr,
  input  logic [7:0]        stg_rdata,
  output logic              mem_we,
  output logic [PAGE_W+7:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [PAGE_W-1:0] next_pg
);
  localparam int AW   = PAGE_W + 8;
  localparam int HC_W = $clog2(HDR_BYTES);

  wr_phase_e          phase_q;
  logic [PAGE_W-1:0]  base_q, start_q, stop_q;
  logic [LEN_W-1:0]   len_q, pad_q, dcnt_q;
  logic [7:0]         stat_q;
  logic [HC_W-1:0]    hcnt_q;
  logic [AW-1:0]      waddr_q, waddr_nx;
  logic [LEN_W-1:0]   tot_len;
  logic [PAGE_W-1:0]  nxt_pg;
  logic               last_byte;

  assign tot_len = pad_q + LEN_W'(HDR_BYTES);

  rxr_next_calc #(
    .PAGE_W   (PAGE_W),
    .LEN_W    (LEN_W),
    .CRC_BYTES(CRC_BYTES)
  ) u_next (
    .base_pg (base_q),
    .start_pg(start_q),
    .stop_pg (stop_q),
    .tot_len (tot_len),
    .next_pg (nxt_pg)
  );

  // address of the byte after the current one, folding at the ring end
  always_comb begin
    waddr_nx = waddr_q + AW'(1);
    if (waddr_nx == {stop_q, 8'h00}) waddr_nx = {start_q, 8'h00};
  end

  assign last_byte = (phase_q == WR_DATA) && (dcnt_q == pad_q - LEN_W'(1));
  assign busy      = (phase_q != WR_IDLE);
  assign done      = last_byte;
  assign next_pg   = nxt_pg;
  assign stg_raddr = (phase_q == WR_DATA) ? SAW'(dcnt_q + LEN_W'(1)) : '0;

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = 8'h00;
    case (phase_q)
      WR_HDR: begin
        mem_we   = 1'b1;
        mem_addr = {base_q, 8'(hcnt_q)};
        case (hcnt_q)
          HC_W'(0): mem_wdata = stat_q;
          HC_W'(1): mem_wdata = 8'(nxt_pg);
          HC_W'(2): mem_wdata = 8'(tot_len);
          HC_W'(3): mem_wdata = 8'(tot_len >> 8);
          default:  mem_wdata = 8'h00;
        endcase
      end
      WR_DATA: begin
        mem_we    = 1'b1;
        mem_addr  = waddr_q;
        mem_wdata = (dcnt_q < len_q) ? stg_rdata : 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= WR_IDLE;
      base_q  <= '0;
      start_q <= '0;
      stop_q  <= '0;
      len_q   <= '0;
      pad_q   <= '0;
      dcnt_q  <= '0;
      stat_q  <= 8'h00;
      hcnt_q  <= '0;
      waddr_q <= '0;
    end else begin
      case (phase_q)
        WR_IDLE: begin
          if (go) begin
            phase_q <= WR_HDR;
            base_q  <= base_pg;
            start_q <= start_pg;
            stop_q  <= stop_pg;
            len_q   <= frame_len;
            pad_q   <= (frame_len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : frame_len;
            stat_q  <= status;
            hcnt_q  <= '0;
          end
        end
        WR_HDR: begin
          hcnt_q <= hcnt_q + HC_W'(1);
          if (hcnt_q == HC_W'(HDR_BYTES - 1)) begin
            phase_q <= WR_DATA;
            dcnt_q  <= '0;
            waddr_q <= {base_q, 8'(HDR_BYTES)};
          end
        end
        WR_DATA: begin
          dcnt_q  <= dcnt_q + LEN_W'(1);
          waddr_q <= waddr_nx;
          if (last_byte) phase_q <= WR_IDLE;
        end
        default: phase_q <= WR_IDLE;
      endcase
    end
  end

  // R9
  wrap_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == WR_DATA && !last_byte && waddr_q == {stop_q, 8'h00} - AW'(1))
      |=> (mem_addr == {start_q, 8'h00}));
endmodule

// File: rtl/rx_page_ring_writer.sv
module rx_page_ring_writer
  import rxr_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60,
  parameter int HDR_BYTES = 4,
  parameter int CRC_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic [PAGE_W-1:0] ring_start_pg,
  input  logic [PAGE_W-1:0] ring_stop_pg,
  input  logic [PAGE_W-1:0] bound_pg,
  input  logic              cur_load,
  input  logic [PAGE_W-1:0] cur_load_pg,
  output logic [PAGE_W-1:0] cur_pg,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_sof,
  input  logic              s_eof,
  output logic              mem_we,
  output logic [PAGE_W+7:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              drop,
  output logic              rx_flag,
  input  logic              rx_flag_clr
);
  localparam int LEN_W   = $clog2(MAX_FRAME + HDR_BYTES + CRC_BYTES + 1);
  localparam int SAW     = $clog2(MAX_FRAME);
  localparam int RESERVE = MAX_FRAME + HDR_BYTES;

  in_state_e         in_q;
  logic [LEN_W-1:0]  len_q;
  logic [7:0]        first_q;
  logic [PAGE_W-1:0] cur_q;
  logic              flag_q, drop_q;
  logic              accept, roomy, take;
  logic              stg_we;
  logic [SAW-1:0]    stg_waddr, stg_raddr;
  logic [7:0]        stg_rdata;
  logic              seq_busy, seq_done, go;
  logic [PAGE_W-1:0] seq_next;
  logic [7:0]        status;

  rxr_space_chk #(
    .PAGE_W (PAGE_W),
    .RESERVE(RESERVE)
  ) u_space (
    .start_pg(ring_start_pg),
    .stop_pg (ring_stop_pg),
    .cur_pg  (cur_q),
    .bnd_pg  (bound_pg),
    .roomy   (roomy)
  );

  assign take    = roomy && !halt;
  assign s_ready = (in_q != IN_LAUNCH) && !seq_busy;
  assign accept  = s_valid && s_ready;
  assign go      = (in_q == IN_LAUNCH);
  assign status  = STAT_GOOD | (first_q[0] ? STAT_GROUP : 8'h00);

  always_comb begin
    stg_we    = 1'b0;
    stg_waddr = SAW'(len_q);
    if (accept) begin
      if (in_q == IN_IDLE && s_sof && take) begin
        stg_we    = 1'b1;
        stg_waddr = '0;
      end else if (in_q == IN_FILL && len_q < LEN_W'(MAX_FRAME)) begin
        stg_we = 1'b1;
      end
    end
  end

  rxr_stage_ram #(
    .SAW(SAW)
  ) u_stage (
    .clk  (clk),
    .we   (stg_we),
    .waddr(stg_waddr),
    .wdata(s_data),
    .raddr(stg_raddr),
    .rdata(stg_rdata)
  );

  rxr_wr_seq #(
    .PAGE_W   (PAGE_W),
    .LEN_W    (LEN_W),
    .SAW      (SAW),
    .MIN_FRAME(MIN_FRAME),
    .HDR_BYTES(HDR_BYTES),
    .CRC_BYTES(CRC_BYTES)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .base_pg  (cur_q),
    .start_pg (ring_start_pg),
    .stop_pg  (ring_stop_pg),
    .frame_len(len_q),
    .status   (status),
    .stg_raddr(stg_raddr),
    .stg_rdata(stg_rdata),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .busy     (seq_busy),
    .done     (seq_done),
    .next_pg  (seq_next)
  );

  // stream-side frame collection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q    <= IN_IDLE;
      len_q   <= '0;
      first_q <= 8'h00;
      drop_q  <= 1'b0;
    end else begin
      drop_q <= 1'b0;
      case (in_q)
        IN_IDLE: begin
          if (accept && s_sof) begin
            if (take) begin
              len_q   <= LEN_W'(1);
              first_q <= s_data;
              in_q    <= s_eof ? IN_LAUNCH : IN_FILL;
            end else begin
              drop_q <= 1'b1;
              in_q   <= s_eof ? IN_IDLE : IN_SKIP;
            end
          end
        end
        IN_FILL: begin
          if (accept) begin
            if (len_q < LEN_W'(MAX_FRAME)) len_q <= len_q + LEN_W'(1);
            if (s_eof) in_q <= IN_LAUNCH;
          end
        end
        IN_SKIP: begin
          if (accept && s_eof) in_q <= IN_IDLE;
        end
        IN_LAUNCH: in_q <= IN_IDLE;
        default:   in_q <= IN_IDLE;
      endcase
    end
  end

  // current page and sticky flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (seq_done)      cur_q <= seq_next;
      else if (cur_load) cur_q <= cur_load_pg;
      if (seq_done)         flag_q <= 1'b1;
      else if (rx_flag_clr) flag_q <= 1'b0;
    end
  end

  assign cur_pg  = cur_q;
  assign rx_flag = flag_q;
  assign busy    = seq_busy;
  assign drop    = drop_q;

  // R4
  drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> $past(s_valid && s_ready && s_sof));
  // R4
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> !mem_we);
  // R10
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(busy));
  // R10
  cur_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (cur_pg == $past(seq_next)));
  // R11
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !s_ready);
endmodule

// File: tb/tb_rx_page_ring_writer.sv
module tb_rx_page_ring_writer;
  typedef struct packed {
    logic [7:0]  cur;
    logic [7:0]  bnd;
    logic [15:0] len;
    logic [7:0]  b0;
    logic        acc;
    logic [7:0]  nxt;
    logic [7:0]  stat;
  } vec_t;

  localparam logic [7:0] RSTART = 8'h02;
  localparam logic [7:0] RSTOP  = 8'h0A;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 8'h02, 16'd64,  8'h10, 1'b1, 8'h03, 8'h01},
    '{8'h03, 8'h03, 16'd20,  8'h01, 1'b1, 8'h04, 8'h21},
    '{8'h09, 8'h09, 16'd300, 8'hFF, 1'b1, 8'h03, 8'h21},
    '{8'h04, 8'h05, 16'd30,  8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h06, 8'h02, 16'd30,  8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h02, 8'h08, 16'd100, 8'h02, 1'b1, 8'h03, 8'h01},
    '{8'h03, 8'h09, 16'd60,  8'h00, 1'b1, 8'h04, 8'h01},
    '{8'h04, 8'h09, 16'd40,  8'h00, 1'b0, 8'h00, 8'h00},
    '{8'h02, 8'h02, 16'd59,  8'h33, 1'b1, 8'h03, 8'h21},
    '{8'h08, 8'h08, 16'd500, 8'h40, 1'b1, 8'h02, 8'h01}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 1'b0;
  logic [7:0] ring_start_pg = RSTART;
  logic [7:0] ring_stop_pg = RSTOP;
  logic [7:0] bound_pg = 8'h02;
  logic cur_load = 1'b0;
  logic [7:0] cur_load_pg = 8'h00;
  logic [7:0] cur_pg;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [7:0] s_data = 8'h00;
  logic s_sof = 1'b0;
  logic s_eof = 1'b0;
  logic mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic busy, drop, rx_flag;
  logic rx_flag_clr = 1'b0;

  int checks = 0;
  int fails = 0;
  int wr_total = 0;
  int drop_total = 0;
  bit finished = 1'b0;
  logic [7:0] bmem [4096];

  always #4 clk = ~clk;

  rx_page_ring_writer dut (
    .clk(clk), .rst_n(rst_n), .halt(halt),
    .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg),
    .bound_pg(bound_pg), .cur_load(cur_load), .cur_load_pg(cur_load_pg),
    .cur_pg(cur_pg), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_eof(s_eof), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .drop(drop), .rx_flag(rx_flag),
    .rx_flag_clr(rx_flag_clr)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr[11:0]] <= mem_wdata;
      wr_total = wr_total + 1;
    end
    if (drop) drop_total = drop_total + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int vid, input int k, input logic [7:0] b0);
    return (k == 0) ? b0 : 8'(k * 3 + vid * 11 + 1);
  endfunction

  task automatic load_cur(input logic [7:0] pg);
    cur_load = 1'b1; cur_load_pg = pg;
    @(negedge clk);
    cur_load = 1'b0;
  endtask

  task automatic clear_flag();
    rx_flag_clr = 1'b1;
    @(negedge clk);
    rx_flag_clr = 1'b0;
  endtask

  task automatic send_frame(input int len, input logic [7:0] b0, input int vid);
    for (int k = 0; k < len; k++) begin
      s_valid = 1'b1; s_data = pat(vid, k, b0);
      s_sof = (k == 0); s_eof = (k == len - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cur_pg", 32'(cur_pg), 32'h00);
    check("R1 flags", {28'h0, rx_flag, busy, drop, mem_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 s_ready", 32'(s_ready), 32'h1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      automatic vec_t t = VECS[v];
      automatic int len = int'(t.len);
      automatic int plen = (len < 60) ? 60 : len;
      automatic int tot = plen + 4;
      automatic int w0, d0, base, bad;
      bound_pg = t.bnd;
      load_cur(t.cur);
      clear_flag();
      w0 = wr_total; d0 = drop_total;
      send_frame(len, t.b0, v);
      wait_idle();
      if (t.acc) begin
        base = int'(t.cur) * 256;
        check($sformatf("R2 R4 v%0d no drop", v), 32'(drop_total - d0), 32'd0);
        check($sformatf("R11 v%0d write count", v), 32'(wr_total - w0), 32'(4 + plen));
        check($sformatf("R5 R6 R8 v%0d descriptor", v),
              {bmem[base], bmem[base + 1], bmem[base + 2], bmem[base + 3]},
              {t.stat, t.nxt, 8'(tot), 8'(tot >> 8)});
        bad = 0;
        for (int k = 0; k < plen; k++) begin
          automatic int a = base + 4 + k;
          automatic logic [7:0] e = (k < len) ? pat(v, k, t.b0) : 8'h00;
          if (a >= int'(RSTOP) * 256) a = a - (int'(RSTOP) - int'(RSTART)) * 256;
          if (bmem[a] !== e) bad++;
        end
        check($sformatf("R7 R9 v%0d data mismatches", v), 32'(bad), 32'd0);
        check($sformatf("R10 v%0d cur_pg", v), 32'(cur_pg), 32'(t.nxt));
        check($sformatf("R10 v%0d flag", v), 32'(rx_flag), 32'h1);
      end else begin
        check($sformatf("R2 R4 v%0d drop pulses", v), 32'(drop_total - d0), 32'd1);
        check($sformatf("R4 v%0d no writes", v), 32'(wr_total - w0), 32'd0);
        check($sformatf("R2 v%0d cur_pg kept", v), 32'(cur_pg), 32'(t.cur));
        check($sformatf("R2 v%0d flag kept", v), 32'(rx_flag), 32'h0);
      end
    end

    // R10 flag clear
    clear_flag();
    check("R10 flag cleared", 32'(rx_flag), 32'h0);

    // R12 current page load
    load_cur(8'h05);
    check("R12 cur_pg loaded", 32'(cur_pg), 32'h05);

    // R3 halted receiver refuses an otherwise fitting frame
    bound_pg = 8'h05;
    halt = 1'b1;
    begin
      automatic int w0 = wr_total;
      automatic int d0 = drop_total;
      send_frame(70, 8'h00, 20);
      wait_idle();
      check("R3 halt drop", 32'(drop_total - d0), 32'd1);
      check("R3 halt no writes", 32'(wr_total - w0), 32'd0);
      check("R3 halt cur_pg", 32'(cur_pg), 32'h05);
    end
    halt = 1'b0;

    // R11 back-pressure while writing
    send_frame(61, 8'h00, 21);
    @(negedge clk);
    check("R11 busy during write", 32'(busy), 32'h1);
    check("R11 ready low while busy", 32'(s_ready), 32'h0);
    wait_idle();
    check("R11 busy ends", 32'(busy), 32'h0);
    check("R10 R8 cur after directed frame", 32'(cur_pg), 32'h06);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule